// File: doc/BRIEF.md
# FSK Modem Frame Receive Sequencer

This block is the host-side controller that takes a 4-level FSK modem through the reception of one whole frame. It sets the modem's mode byte for receiving and waits until the carrier has been steady for a programmable number of symbol times. It then starts a combined symbol-sync, frame-sync and header task. After that it requests each following block in turn with a block-read task.

Before every task write, the sequencer reads the modem status register and checks the buffer-free flag. After every task it waits for the active-low interrupt and reads status again to check the completion flags. It then reads the block's bytes from the modem data buffer. Each byte is forwarded on a registered byte stream, tagged with its block type and with an end-of-block flag.

Any failed check ends the frame. A sticky error and its error code stay up until the next start. The number of intermediate blocks is given on `n_inter` when the frame starts.

Top module: `fsk_rx_seq`

## Requirements
- R1: Once `start` is seen, the first register write sets the mode register (address 3) to 0x01. That value means interrupts enabled in bit 0, receive direction (bit 1 = 0), and power-save (bit 2) and eye-diagram (bit 3) off. This write comes before any command write.
- R2: No command is written until `carrier` has been high for WAIT_SYMS*SYM_CLKS consecutive clocks. A drop of the carrier restarts the count.
- R3: Each command write is preceded by a status read (address 1) whose buffer-free bit 6 is 1. If that bit is 0, no command is written and the frame ends with error code 3. Error code 3 is also raised when the post-interrupt status lacks IRQ (bit 7) or buffer-free.
- R4: Commands go to address 0. The first is 0xC1: sync-and-header task code 1 in bits 2:0, with the clock-acquire bit 7 and level-acquire bit 6 set. Every later command is 0x02 (block-read task code 2).
- R5: After each command, the sequencer waits for `irq_n` low and then reads status. If the overflow bit 4 is 1, the frame ends with error code 2 and the block's bytes are not read.
- R6: The header block gives exactly HDR_BYTES (10) bytes tagged kind 0. A CRC error (status bit 5) on the header ends the frame with error code 1 before any header byte is read.
- R7: Each intermediate block gives exactly INT_BYTES (12) bytes tagged kind 1. The CRC error bit is ignored for these blocks.
- R8: The last block gives exactly LAST_BYTES (8) bytes tagged kind 2. A CRC error on it ends the frame with error code 1 before any of its bytes are read.
- R9: Exactly `n_inter` intermediate blocks are read. With zero, the last block follows the header directly.
- R10: `byte_end` marks the final byte of every block. No byte is emitted while `err` is high. `err` and `err_code` hold until the next `start`, which clears them. `done` pulses for one cycle, together with the final byte of a frame that had no error.
- R11: After reset the block is idle: `busy`, `done`, `err`, `byte_valid`, `reg_wr` and `reg_rd` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame (taken while idle) |
| n_inter | input | NBW | Intermediate block count for the frame |
| carrier | input | 1 | Carrier present |
| irq_n | input | 1 | Modem interrupt, active low |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe; data returns the next cycle |
| reg_addr | output | 2 | 0 command, 1 status, 2 data buffer, 3 mode |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data, one cycle after `reg_rd` |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse when a frame ends with no error |
| err | output | 1 | Sticky error flag |
| err_code | output | 2 | 0 none, 1 CRC, 2 overflow, 3 not free / no IRQ |
| byte_valid | output | 1 | Byte stream valid |
| byte_data | output | 8 | Received byte |
| byte_kind | output | 2 | 0 header, 1 intermediate, 2 last |
| byte_end | output | 1 | Final byte of its block |

## Verification
Clean frames with zero, one and three intermediate blocks are run to show that the block count, the per-kind byte counts, the tags and the end flags all follow `n_inter`. Injected CRC errors on the header, on an intermediate block and on the last block show that the CRC check applies to the header and last blocks only. Overflow and not-free injections at several block positions show the error priority and that the byte stream stops exactly at the failing block. A directed run holds the carrier low, then glitches it, then raises it. This measures the delay from a steady carrier to the first command and confirms the sticky error and its clearing on restart.

// File: rtl/fsk_rx_pkg.sv
package fsk_rx_pkg;

  localparam logic [1:0] ADDR_CMD  = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
  localparam logic [1:0] ADDR_MODE = 2'd3;

  localparam int ST_IRQ  = 7;
  localparam int ST_FREE = 6;
  localparam int ST_CRC  = 5;
  localparam int ST_OVF  = 4;

  localparam logic [7:0] MODE_RX      = 8'h01;
  localparam logic [7:0] CMD_SYNC_HDR = 8'hC1;
  localparam logic [7:0] CMD_NEXT_BLK = 8'h02;

  typedef enum logic [1:0] {
    BLK_HDR  = 2'd0,
    BLK_INT  = 2'd1,
    BLK_LAST = 2'd2
  } blk_e;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_CRC  = 2'd1,
    ERR_OVF  = 2'd2,
    ERR_BUSY = 2'd3
  } err_e;

endpackage

// File: rtl/fsk_rx_carrier_timer.sv
module fsk_rx_carrier_timer #(
  parameter int LIM = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic carrier,
  output logic ready
);
  localparam int CW = (LIM > 2) ? $clog2(LIM) : 1;
  localparam logic [CW-1:0] TOP = CW'(LIM - 1);

  logic [CW-1:0] cnt;

  // counts consecutive carrier-high cycles while enabled
  always_ff @(posedge clk) begin
    if (rst || !en || !carrier) cnt <= '0;
    else if (cnt != TOP) cnt <= cnt + 1'b1;
  end

  assign ready = en && carrier && (cnt == TOP);
endmodule

// File: rtl/fsk_rx_status_eval.sv
module fsk_rx_status_eval import fsk_rx_pkg::*; (
  input  logic [7:0] stat,
  input  logic       post,
  input  blk_e       kind,
  output logic       ok,
  output err_e       code
);
  always_comb begin
    ok   = 1'b1;
    code = ERR_NONE;
    if (!post) begin
      if (!stat[ST_FREE]) begin
        ok   = 1'b0;
        code = ERR_BUSY;
      end
    end else if (stat[ST_OVF]) begin
      ok   = 1'b0;
      code = ERR_OVF;
    end else if (!stat[ST_IRQ] || !stat[ST_FREE]) begin
      ok   = 1'b0;
      code = ERR_BUSY;
    end else if (stat[ST_CRC] && kind != BLK_INT) begin
      ok   = 1'b0;
      code = ERR_CRC;
    end
  end
endmodule

// File: rtl/fsk_rx_byte_out.sv
module fsk_rx_byte_out import fsk_rx_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  blk_e       in_kind,
  input  logic       in_end,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic [1:0] out_kind,
  output logic       out_end
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_kind  <= '0;
      out_end   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_end   <= in_valid && in_end;
      if (in_valid) begin
        out_data <= in_data;
        out_kind <= in_kind;
      end
    end
  end
endmodule

// File: rtl/fsk_rx_seq.sv
module fsk_rx_seq import fsk_rx_pkg::*; #(
  parameter int SYM_CLKS   = 4,
  parameter int WAIT_SYMS  = 8,
  parameter int NBW        = 8,
  parameter int HDR_BYTES  = 10,
  parameter int INT_BYTES  = 12,
  parameter int LAST_BYTES = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [NBW-1:0] n_inter,
  input  logic           carrier,
  input  logic           irq_n,
  output logic           reg_wr,
  output logic           reg_rd,
  output logic [1:0]     reg_addr,
  output logic [7:0]     reg_wdata,
  input  logic [7:0]     reg_rdata,
  output logic           busy,
  output logic           done,
  output logic           err,
  output logic [1:0]     err_code,
  output logic           byte_valid,
  output logic [7:0]     byte_data,
  output logic [1:0]     byte_kind,
  output logic           byte_end
);
  localparam int WAIT_CLKS = SYM_CLKS * WAIT_SYMS;
  localparam int MAX_HI    = (HDR_BYTES > INT_BYTES) ? HDR_BYTES : INT_BYTES;
  localparam int MAXB      = (MAX_HI > LAST_BYTES) ? MAX_HI : LAST_BYTES;
  localparam int BCW       = (MAXB > 2) ? $clog2(MAXB) : 1;

  typedef enum logic [3:0] {
    S_IDLE, S_MODE, S_CARR, S_PRE_RD, S_PRE_CHK, S_CMD,
    S_IRQ, S_POST_RD, S_POST_CHK, S_DAT_RD, S_DAT_GET
  } st_e;

  st_e            state;
  blk_e           kind;
  logic [NBW-1:0] n_left;
  logic [BCW-1:0] bcnt;
  logic [BCW-1:0] last_idx;
  logic           carr_ready;
  logic           chk_ok;
  err_e           chk_code;

  fsk_rx_carrier_timer #(.LIM(WAIT_CLKS)) timer_i (
    .clk     (clk),
    .rst     (rst),
    .en      (state == S_CARR),
    .carrier (carrier),
    .ready   (carr_ready)
  );

  fsk_rx_status_eval eval_i (
    .stat (reg_rdata),
    .post (state == S_POST_CHK),
    .kind (kind),
    .ok   (chk_ok),
    .code (chk_code)
  );

  always_comb begin
    case (kind)
      BLK_HDR: last_idx = BCW'(HDR_BYTES - 1);
      BLK_INT: last_idx = BCW'(INT_BYTES - 1);
      default: last_idx = BCW'(LAST_BYTES - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      kind     <= BLK_HDR;
      n_left   <= '0;
      bcnt     <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      err_code <= ERR_NONE;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          err      <= 1'b0;
          err_code <= ERR_NONE;
          n_left   <= n_inter;
          kind     <= BLK_HDR;
          state    <= S_MODE;
        end
        S_MODE:   state <= S_CARR;
        S_CARR:   if (carr_ready) state <= S_PRE_RD;
        S_PRE_RD: state <= S_PRE_CHK;
        S_PRE_CHK: begin
          if (chk_ok) state <= S_CMD;
          else begin
            err      <= 1'b1;
            err_code <= chk_code;
            state    <= S_IDLE;
          end
        end
        S_CMD:     state <= S_IRQ;
        S_IRQ:     if (!irq_n) state <= S_POST_RD;
        S_POST_RD: state <= S_POST_CHK;
        S_POST_CHK: begin
          bcnt <= '0;
          if (chk_ok) state <= S_DAT_RD;
          else begin
            err      <= 1'b1;
            err_code <= chk_code;
            state    <= S_IDLE;
          end
        end
        S_DAT_RD: state <= S_DAT_GET;
        S_DAT_GET: begin
          if (bcnt == last_idx) begin
            if (kind == BLK_LAST) begin
              done  <= 1'b1;
              state <= S_IDLE;
            end else begin
              if (n_left == '0) kind <= BLK_LAST;
              else begin
                kind   <= BLK_INT;
                n_left <= n_left - 1'b1;
              end
              state <= S_PRE_RD;
            end
          end else begin
            bcnt  <= bcnt + 1'b1;
            state <= S_DAT_RD;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    reg_wr    = 1'b0;
    reg_rd    = 1'b0;
    reg_addr  = ADDR_CMD;
    reg_wdata = '0;
    case (state)
      S_MODE: begin
        reg_wr    = 1'b1;
        reg_addr  = ADDR_MODE;
        reg_wdata = MODE_RX;
      end
      S_PRE_RD, S_POST_RD: begin
        reg_rd   = 1'b1;
        reg_addr = ADDR_STAT;
      end
      S_CMD: begin
        reg_wr    = 1'b1;
        reg_addr  = ADDR_CMD;
        reg_wdata = (kind == BLK_HDR) ? CMD_SYNC_HDR : CMD_NEXT_BLK;
      end
      S_DAT_RD: begin
        reg_rd   = 1'b1;
        reg_addr = ADDR_DATA;
      end
      default: ;
    endcase
  end

  assign busy = (state != S_IDLE);

  fsk_rx_byte_out out_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (state == S_DAT_GET),
    .in_data   (reg_rdata),
    .in_kind   (kind),
    .in_end    (bcnt == last_idx),
    .out_valid (byte_valid),
    .out_data  (byte_data),
    .out_kind  (byte_kind),
    .out_end   (byte_end)
  );
endmodule

// File: rtl/fsk_rx_seq_chk.sv
module fsk_rx_seq_chk import fsk_rx_pkg::*; #(
  parameter int SYM_CLKS  = 4,
  parameter int WAIT_SYMS = 8
) (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       carrier,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       done,
  input logic       err,
  input logic [1:0] err_code,
  input logic       byte_valid,
  input logic       byte_end
);
  localparam int LIM = SYM_CLKS * WAIT_SYMS;
  localparam int CW  = $clog2(LIM + 1);

  logic [CW-1:0] carr_cnt;
  logic          stat_rd_q;
  logic          free_seen;
  logic          cmd_wr;

  assign cmd_wr = reg_wr && (reg_addr == ADDR_CMD);

  always_ff @(posedge clk) begin
    if (rst || !carrier) carr_cnt <= '0;
    else if (carr_cnt != CW'(LIM)) carr_cnt <= carr_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_rd_q <= 1'b0;
      free_seen <= 1'b0;
    end else begin
      stat_rd_q <= reg_rd && (reg_addr == ADDR_STAT);
      if (cmd_wr) free_seen <= 1'b0;
      else if (stat_rd_q) free_seen <= reg_rdata[ST_FREE];
    end
  end

  assert_bus_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_rd));

  assert_free_before_cmd_R3: assert property (@(posedge clk) disable iff (rst)
    cmd_wr |-> free_seen);

  assert_carrier_settled_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && reg_wdata == CMD_SYNC_HDR) |-> (carr_cnt >= CW'(LIM)));

  assert_quiet_after_err_R10: assert property (@(posedge clk) disable iff (rst)
    err |-> !byte_valid);

  assert_end_in_stream_R10: assert property (@(posedge clk) disable iff (rst)
    byte_end |-> byte_valid);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (err && !start) |=> (err && $stable(err_code)));

  assert_done_clean_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> (!err && byte_valid && byte_end));
endmodule

bind fsk_rx_seq fsk_rx_seq_chk #(.SYM_CLKS(SYM_CLKS), .WAIT_SYMS(WAIT_SYMS)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .carrier    (carrier),
  .reg_wr     (reg_wr),
  .reg_rd     (reg_rd),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .done       (done),
  .err        (err),
  .err_code   (err_code),
  .byte_valid (byte_valid),
  .byte_end   (byte_end)
);

// File: tb/fsk_rx_seq_tb_top.sv
module fsk_rx_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SYM        = 4;
  localparam int WSYM       = 8;
  localparam int WAITC      = SYM * WSYM;
  localparam int NVEC       = 10;
  // {n_inter[11:8], fault[5:4], fault block[3:0]}; fault 0 none,1 crc,2 ovf,3 not free
  localparam logic [11:0] VEC [NVEC] = '{
    12'h0_00, 12'h1_00, 12'h3_00, 12'h2_10, 12'h2_11,
    12'h2_13, 12'h1_21, 12'h2_32, 12'h0_20, 12'h0_11
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] n_inter = '0;
  logic       carrier = 1'b1;
  logic       irq_n;
  logic       reg_wr, reg_rd;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       busy, done, err, byte_valid, byte_end;
  logic [1:0] err_code, byte_kind;
  logic [7:0] byte_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  fsk_rx_seq #(.SYM_CLKS(SYM), .WAIT_SYMS(WSYM)) dut_i (
    .clk(clk), .rst(rst), .start(start), .n_inter(n_inter), .carrier(carrier),
    .irq_n(irq_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .done(done),
    .err(err), .err_code(err_code), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_kind(byte_kind), .byte_end(byte_end)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // modem model
  logic [1:0] m_fault = '0;
  int         m_fblk = 0;
  logic       m_clr = 1'b0;
  logic       m_irq;
  int         m_cmdcnt, m_curblk, m_delay, m_dctr;
  logic [7:0] m_stat;

  assign irq_n = !m_irq;
  always_comb begin
    m_stat = 8'h00;
    m_stat[7] = m_irq;
    m_stat[6] = !(m_fault == 2'd3 && m_cmdcnt == m_fblk && !m_irq);
    m_stat[5] = m_irq && m_fault == 2'd1 && m_curblk == m_fblk;
    m_stat[4] = m_irq && m_fault == 2'd2 && m_curblk == m_fblk;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst || m_clr) begin
      m_irq <= 1'b0; m_cmdcnt <= 0; m_curblk <= 0; m_delay <= 0; m_dctr <= 0;
      reg_rdata <= '0;
    end else begin
      if (m_delay > 1) m_delay <= m_delay - 1;
      else if (m_delay == 1) begin m_delay <= 0; m_irq <= 1'b1; end
      if (reg_wr && reg_addr == 2'd0) begin
        m_curblk <= m_cmdcnt; m_cmdcnt <= m_cmdcnt + 1; m_delay <= 6;
      end
      if (reg_rd && reg_addr == 2'd1) begin reg_rdata <= m_stat; m_irq <= 1'b0; end
      if (reg_rd && reg_addr == 2'd2) begin reg_rdata <= m_dctr[7:0]; m_dctr <= m_dctr + 1; end
    end
  end

  // bench monitors
  int   cur_n = 0;
  int   b_count, b_mis, c_count, c_bad, first_cmd_cyc, mode_val, mode_early;

  function automatic int kind_of(int i, int n);
    if (i < 10) return 0;
    if (i - 10 < 12 * n) return 1;
    return 2;
  endfunction

  function automatic bit end_of(int i, int n);
    if (i < 10) return i == 9;
    if (i - 10 < 12 * n) return ((i - 10) % 12) == 11;
    return (i - 10 - 12 * n) == 7;
  endfunction

  always @(negedge clk) begin
    if (!rst && byte_valid) begin
      if (byte_data != b_count[7:0] || byte_kind != kind_of(b_count, cur_n)
          || byte_end != end_of(b_count, cur_n)) b_mis = b_mis + 1;
      b_count = b_count + 1;
    end
    if (!rst && reg_wr && reg_addr == 2'd0) begin
      if (c_count == 0) begin
        first_cmd_cyc = cyc;
        if (reg_wdata != 8'hC1) c_bad = c_bad + 1;
      end else if (reg_wdata != 8'h02) c_bad = c_bad + 1;
      c_count = c_count + 1;
    end
    if (!rst && reg_wr && reg_addr == 2'd3) begin
      mode_val   = reg_wdata;
      mode_early = (c_count == 0);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int blen(int b, int n);
    if (b == 0) return 10;
    if (b <= n) return 12;
    return 8;
  endfunction

  task automatic clear_mon();
    @(posedge clk); #1;
    b_count = 0; b_mis = 0; c_count = 0; c_bad = 0;
    first_cmd_cyc = 0; mode_val = -1; mode_early = 0;
    m_clr = 1'b1;
    @(posedge clk); #1;
    m_clr = 1'b0;
  endtask

  task automatic pulse_start(input int n);
    cur_n   = n;
    n_inter = n[7:0];
    start   = 1'b1;
    @(posedge clk); #1;
    start   = 1'b0;
  endtask

  task automatic wait_end();
    int t = 0;
    while (!(done || err) && t < 4000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
  endtask

  initial begin : main
    int t0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(!busy && !done && !err && !byte_valid && !reg_wr && !reg_rd, "R11",
          "idle after reset", {busy, done, err, byte_valid, reg_wr, reg_rd}, 0);

    for (int v = 0; v < NVEC; v++) begin
      int n, f, fb, exp_code, exp_bytes, exp_cmds, blocks;
      n  = VEC[v][11:8];
      f  = VEC[v][5:4];
      fb = VEC[v][3:0];
      blocks = n + 2;
      exp_code = f;
      if (f == 1 && fb >= 1 && fb <= n) exp_code = 0;   // R7 crc ignored mid-frame
      if (exp_code == 0) begin
        exp_bytes = 10 + 12 * n + 8;
        exp_cmds  = blocks;
      end else begin
        exp_bytes = 0;
        for (int b = 0; b < fb; b++) exp_bytes += blen(b, n);
        exp_cmds = (f == 3) ? fb : fb + 1;
      end
      clear_mon();
      m_fault = f[1:0];
      m_fblk  = fb;
      pulse_start(n);
      @(negedge clk);
      check(!err, "R10", "err cleared by start", err, 0);
      wait_end();
      check(err_code == exp_code[1:0], (f == 2) ? "R5" : (f == 3) ? "R3" : (fb == 0) ? "R6" : "R8",
            "error code", err_code, exp_code);
      check(err == (exp_code != 0), "R10", "sticky err flag", err, exp_code != 0);
      check(b_count == exp_bytes, "R9", "byte count", b_count, exp_bytes);
      check(b_mis == 0, "R7", "byte values kinds and end flags (R6 R8)", b_mis, 0);
      check(c_count == exp_cmds && c_bad == 0, "R4", "command writes", c_count * 100 + c_bad,
            exp_cmds * 100);
      check(mode_val == 8'h01 && mode_early == 1, "R1", "mode write", mode_val, 1);
      if (exp_code != 0) begin
        repeat (40) @(negedge clk);
        check(err && err_code == exp_code[1:0] && !byte_valid, "R10", "error held",
              err_code, exp_code);
      end
    end

    // R2 carrier qualification, with glitch
    clear_mon();
    m_fault = 2'd0;
    carrier = 1'b0;
    pulse_start(0);
    repeat (100) @(negedge clk);
    check(c_count == 0 && busy, "R2", "no command without carrier", c_count, 0);
    carrier = 1'b1;
    repeat (WAITC - 6) @(negedge clk);
    carrier = 1'b0;
    repeat (5) @(negedge clk);
    check(c_count == 0, "R2", "no command after short carrier", c_count, 0);
    carrier = 1'b1;
    t0 = cyc;
    wait_end();
    check(c_count > 0 && first_cmd_cyc - t0 >= WAITC && first_cmd_cyc - t0 <= WAITC + 4,
          "R2", "carrier to first command delay", first_cmd_cyc - t0, WAITC);
    check(done == 1'b0 && err == 1'b0 && b_count == 18, "R9", "zero-intermediate frame",
          b_count, 18);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R10 actual=%0d expected=%0d", 150000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule